// File: doc/BRIEF.md
# SRAM Power-Down Handshake Controller

This block takes the SRAM banks of one power domain into and out of power-down. Each bank has one power-down line and returns one acknowledge line. The block drives the power-down field as a whole. It then waits until every acknowledge bit agrees before it reports completion. The acknowledge lines come from the SRAM supply domain, so they pass through a two-stage synchroniser before any comparison.

When the domain supports isolation, the block also drives two isolation controls around the power-down change:

- an SRAM clock clamp, active high;
- an internal isolation release, active high, meaning not isolated.

On power-up, the release rises once every bank has acknowledged, and the clock clamp drops a fixed number of cycles later. On power-down the order is reversed: the clamp rises first, the release drops after the same delay, and the power-down lines rise on the following cycle.

Every acknowledge wait is bounded. If the wait runs out, the operation is aborted with a one-cycle timeout pulse and the outputs are left where they stand.

Top module: `sram_pd_ctrl`

## Requirements
- R1: Under reset and right after it, `pdn_o` is all ones, `busy_o`, `done_o` and `timeout_o` are 0, and with `iso_cap_i` high `clk_iso_o` is 1 and `iso_rel_o` is 0.
- R2: A power-up request clears every `pdn_o` bit in the cycle after the request edge. `done_o` is raised only after every acknowledge bit has been seen at 0.
- R3: A power-down request ends with every `pdn_o` bit set. `done_o` is raised only after every acknowledge bit has been seen at 1.
- R4: Power-up with `iso_cap_i` high: `iso_rel_o` rises only once all acknowledge bits are 0. `clk_iso_o` falls exactly `ISO_DLY` cycles after that rise, in the cycle `done_o` is raised.
- R5: Power-down with `iso_cap_i` high: `clk_iso_o` rises at the request edge. `iso_rel_o` falls `ISO_DLY` cycles later. The `pdn_o` bits rise one cycle after that fall.
- R6: With `iso_cap_i` low, `clk_iso_o` is 0 and `iso_rel_o` is 1 at all times. The held isolation state follows the last completed operation, so raising `iso_cap_i` after a completed power-down shows `clk_iso_o`=1 and `iso_rel_o`=0.
- R7: If the acknowledge target is not reached within `TMO_CYC` cycles of the wait, the block aborts:
  - `timeout_o` pulses exactly `TMO_CYC` cycles after the wait begins;
  - `busy_o` is already low in that pulse cycle;
  - no `done_o` pulse follows;
  - `pdn_o` and the isolation outputs keep their values.
- R8: `busy_o` is high from the cycle after the accepted request until completion or abort. Requests that arrive while busy are ignored, and `pdn_o` changes only while busy.
- R9: If both requests are high in the same idle cycle, power-up wins.
- R10: `done_o` and `timeout_o` are single-cycle pulses and never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_req_i | input | 1 | Power-up request, sampled when idle |
| dis_req_i | input | 1 | Power-down request, sampled when idle |
| iso_cap_i | input | 1 | Domain supports isolation sequencing (static) |
| ack_i | input | MASK_W | Per-bank power-down acknowledge, asynchronous |
| pdn_o | output | MASK_W | Per-bank power-down control, 1 = powered down |
| clk_iso_o | output | 1 | SRAM clock clamp, 1 = clamped |
| iso_rel_o | output | 1 | Internal isolation release, 1 = released |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle pulse on successful completion |
| timeout_o | output | 1 | One-cycle pulse on acknowledge wait expiry |

## Verification
The bench models banks whose acknowledges lag the power-down lines by a different number of cycles per bit. A controller that tested any single bit, rather than the whole field, would then release isolation or raise `done_o` while slow banks still disagree.

Stuck-bit cases check that the wait is bounded at exactly `TMO_CYC` cycles and that the outputs are held on abort. A design that released isolation anyway, or reported done, fails there.

The isolation windows are counted cycle by cycle in both directions, which catches an off-by-one delay or a swapped order. Requests injected mid-sequence and simultaneous requests expose a controller that restarts while busy or gives power-down priority.

// File: rtl/sram_pd_pkg.sv
package sram_pd_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_EN_ACK,
    ST_EN_DLY,
    ST_DIS_DLY,
    ST_DIS_PDN,
    ST_DIS_ACK
  } pd_state_e;
endpackage

// File: rtl/sram_ack_sync.sv
module sram_ack_sync #(
  parameter int unsigned WIDTH  = 4,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);
  logic [WIDTH-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stage_q[s] <= '0;
      else if (s == 0) stage_q[s] <= async_i;
      else stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
    end
  end

  assign sync_o = stage_q[STAGES-1];
endmodule

// File: rtl/sram_pd_timer.sv
module sram_pd_timer #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  input  logic             dec_i,
  output logic             zero_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else if (load_i) cnt_q <= load_val_i;
    else if (dec_i && cnt_q != '0) cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/sram_pd_ctrl.sv
module sram_pd_ctrl
  import sram_pd_pkg::*;
#(
  parameter int unsigned MASK_W  = 4,
  parameter int unsigned ISO_DLY = 250,
  parameter int unsigned TMO_CYC = 250000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_req_i,
  input  logic              dis_req_i,
  input  logic              iso_cap_i,
  input  logic [MASK_W-1:0] ack_i,
  output logic [MASK_W-1:0] pdn_o,
  output logic              clk_iso_o,
  output logic              iso_rel_o,
  output logic              busy_o,
  output logic              done_o,
  output logic              timeout_o
);
  localparam int unsigned MAX_CNT = (ISO_DLY > TMO_CYC) ? ISO_DLY : TMO_CYC;
  localparam int unsigned CNT_W   = $clog2(MAX_CNT + 1);
  localparam logic [CNT_W-1:0] DLY_LD = CNT_W'(ISO_DLY - 1);
  localparam logic [CNT_W-1:0] TMO_LD = CNT_W'(TMO_CYC - 1);

  pd_state_e state_q, state_d;
  logic [MASK_W-1:0] pdn_q, pdn_d, ack_s;
  logic ciso_q, ciso_d, rel_q, rel_d;
  logic done_q, done_d, tmo_q, tmo_d;
  logic ld, dec, tmr_zero;
  logic [CNT_W-1:0] ld_val;
  logic ack_all_lo, ack_all_hi;

  sram_ack_sync #(.WIDTH(MASK_W), .STAGES(2)) u_sync (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .async_i (ack_i),
    .sync_o  (ack_s)
  );

  sram_pd_timer #(.CNT_W(CNT_W)) u_tmr (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (ld),
    .load_val_i (ld_val),
    .dec_i      (dec),
    .zero_o     (tmr_zero)
  );

  assign ack_all_lo = ~|ack_s;
  assign ack_all_hi = &ack_s;

  always_comb begin
    state_d = state_q;
    pdn_d   = pdn_q;
    ciso_d  = ciso_q;
    rel_d   = rel_q;
    done_d  = 1'b0;
    tmo_d   = 1'b0;
    ld      = 1'b0;
    ld_val  = TMO_LD;
    dec     = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (en_req_i) begin
          pdn_d   = '0;
          ld      = 1'b1;
          state_d = ST_EN_ACK;
        end else if (dis_req_i) begin
          if (iso_cap_i) begin
            ciso_d  = 1'b1;
            ld      = 1'b1;
            ld_val  = DLY_LD;
            state_d = ST_DIS_DLY;
          end else begin
            pdn_d   = '1;
            ld      = 1'b1;
            state_d = ST_DIS_ACK;
          end
        end
      end
      ST_EN_ACK: begin
        if (ack_all_lo) begin
          if (iso_cap_i) begin
            rel_d   = 1'b1;
            ld      = 1'b1;
            ld_val  = DLY_LD;
            state_d = ST_EN_DLY;
          end else begin
            // mirror the released state for a later capability change
            rel_d   = 1'b1;
            ciso_d  = 1'b0;
            done_d  = 1'b1;
            state_d = ST_IDLE;
          end
        end else if (tmr_zero) begin
          tmo_d   = 1'b1;
          state_d = ST_IDLE;
        end else begin
          dec = 1'b1;
        end
      end
      ST_EN_DLY: begin
        if (tmr_zero) begin
          ciso_d  = 1'b0;
          done_d  = 1'b1;
          state_d = ST_IDLE;
        end else begin
          dec = 1'b1;
        end
      end
      ST_DIS_DLY: begin
        if (tmr_zero) begin
          rel_d   = 1'b0;
          state_d = ST_DIS_PDN;
        end else begin
          dec = 1'b1;
        end
      end
      ST_DIS_PDN: begin
        pdn_d   = '1;
        ld      = 1'b1;
        state_d = ST_DIS_ACK;
      end
      ST_DIS_ACK: begin
        if (ack_all_hi) begin
          if (!iso_cap_i) begin
            ciso_d = 1'b1;
            rel_d  = 1'b0;
          end
          done_d  = 1'b1;
          state_d = ST_IDLE;
        end else if (tmr_zero) begin
          tmo_d   = 1'b1;
          state_d = ST_IDLE;
        end else begin
          dec = 1'b1;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      pdn_q   <= '1;
      ciso_q  <= 1'b1;
      rel_q   <= 1'b0;
      done_q  <= 1'b0;
      tmo_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      pdn_q   <= pdn_d;
      ciso_q  <= ciso_d;
      rel_q   <= rel_d;
      done_q  <= done_d;
      tmo_q   <= tmo_d;
    end
  end

  assign pdn_o     = pdn_q;
  assign clk_iso_o = iso_cap_i ? ciso_q : 1'b0;
  assign iso_rel_o = iso_cap_i ? rel_q : 1'b1;
  assign busy_o    = (state_q != ST_IDLE);
  assign done_o    = done_q;
  assign timeout_o = tmo_q;
endmodule

// File: rtl/sram_pd_chk.sv
module sram_pd_chk #(
  parameter int unsigned MASK_W = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              en_req_i,
  input logic              dis_req_i,
  input logic              iso_cap_i,
  input logic [MASK_W-1:0] pdn_o,
  input logic              clk_iso_o,
  input logic              iso_rel_o,
  input logic              busy_o,
  input logic              done_o,
  input logic              timeout_o
);
  // R10
  done_tmo_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(done_o && timeout_o));

  // R10
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  // R10
  tmo_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    timeout_o |=> !timeout_o);

  // R7
  tmo_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    timeout_o |-> !busy_o);

  // R8
  busy_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(en_req_i || dis_req_i));

  // R8
  pdn_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(pdn_o) |-> busy_o);

  // R4
  rel_powered_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (iso_cap_i && $stable(iso_cap_i) && $rose(iso_rel_o)) |-> (pdn_o == '0));

  // R5
  pdn_isolated_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (iso_cap_i && $stable(iso_cap_i) && $rose(|pdn_o)) |-> (clk_iso_o && !iso_rel_o));
endmodule

bind sram_pd_ctrl sram_pd_chk #(.MASK_W(MASK_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .en_req_i  (en_req_i),
  .dis_req_i (dis_req_i),
  .iso_cap_i (iso_cap_i),
  .pdn_o     (pdn_o),
  .clk_iso_o (clk_iso_o),
  .iso_rel_o (iso_rel_o),
  .busy_o    (busy_o),
  .done_o    (done_o),
  .timeout_o (timeout_o)
);

// File: tb/tb_sram_pd_ctrl.sv
module tb_sram_pd_ctrl;
  localparam int MASK_W  = 4;
  localparam int ISO_DLY = 8;
  localparam int TMO_CYC = 40;
  localparam int HIST    = MASK_W + 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en_req = 1'b0, dis_req = 1'b0, iso_cap = 1'b1;
  logic [MASK_W-1:0] ack = '1;
  logic [MASK_W-1:0] pdn;
  logic clk_iso, iso_rel, busy, done, tmo;

  int checks = 0, errors = 0;
  bit finished = 1'b0;

  logic [MASK_W-1:0] stuck_mask = '0, stuck_val = '0;
  logic [MASK_W-1:0] hist [HIST];

  int lat, n_ov, n_gap, iso_bad, inj_at;
  bit got_done, got_tmo, inj_both, rel_prev;
  logic [MASK_W-1:0] pdn_after_req, ack_at_rel, ack_at_end;
  logic busy_after_req;

  always #2 clk = ~clk;

  sram_pd_ctrl #(.MASK_W(MASK_W), .ISO_DLY(ISO_DLY), .TMO_CYC(TMO_CYC)) dut (
    .clk_i(clk), .rst_ni(rst_n), .en_req_i(en_req), .dis_req_i(dis_req),
    .iso_cap_i(iso_cap), .ack_i(ack), .pdn_o(pdn), .clk_iso_o(clk_iso),
    .iso_rel_o(iso_rel), .busy_o(busy), .done_o(done), .timeout_o(tmo)
  );

  // bank model: ack bit i follows pdn bit i after i+1 negedges
  initial begin
    for (int h = 0; h < HIST; h++) hist[h] = '1;
    forever begin
      @(negedge clk);
      for (int h = HIST-1; h > 0; h--) hist[h] = hist[h-1];
      hist[0] = pdn;
      for (int b = 0; b < MASK_W; b++)
        ack[b] = stuck_mask[b] ? stuck_val[b] : hist[b+1][b];
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 4);
    errors++;
    $display("FAIL watchdog actual=0 expected=1");
    finish_run();
  end

  task automatic sample();
    if (iso_rel && clk_iso) n_ov++;
    if (!iso_rel && clk_iso && pdn == '0 && busy) n_gap++;
    if (!iso_cap && (clk_iso || !iso_rel)) iso_bad++;
    if (iso_rel && !rel_prev) ack_at_rel = ack;
    rel_prev = iso_rel;
  endtask

  task automatic do_op(input bit up, input bit both);
    n_ov = 0; n_gap = 0; iso_bad = 0; got_done = 0; got_tmo = 0;
    ack_at_rel = 'x;
    @(negedge clk);
    rel_prev = iso_rel;
    en_req = up | both;
    dis_req = !up | both;
    @(negedge clk);
    en_req = 0; dis_req = 0;
    pdn_after_req = pdn;
    busy_after_req = busy;
    lat = 0;
    for (int i = 0; i < 2000; i++) begin
      sample();
      if (done || tmo) break;
      @(negedge clk);
      lat++;
      if (lat == inj_at) begin en_req = inj_both; dis_req = 1'b1; end
      else begin en_req = 1'b0; dis_req = 1'b0; end
    end
    got_done = done;
    got_tmo = tmo;
    ack_at_end = ack;
    inj_at = -1;
  endtask

  task automatic t_reset();
    rst_n = 0;
    repeat (3) @(negedge clk);
    chk(pdn == '1, "R1 pdn", int'(pdn), int'({MASK_W{1'b1}}));
    chk(clk_iso == 1 && iso_rel == 0, "R1 iso", {clk_iso, iso_rel}, 2);
    chk(!busy && !done && !tmo, "R1 status", {busy, done, tmo}, 0);
    rst_n = 1;
    repeat (8) @(negedge clk);
    chk(pdn == '1 && !busy, "R1 after release", int'(pdn), int'({MASK_W{1'b1}}));
  endtask

  task automatic t_enable_iso();
    iso_cap = 1;
    do_op(1, 0);
    chk(pdn_after_req == '0, "R2 pdn cleared", int'(pdn_after_req), 0);
    chk(busy_after_req, "R8 busy", busy_after_req, 1);
    chk(got_done && !got_tmo, "R2 done", got_done, 1);
    chk(ack_at_end == '0, "R2 ack at done", int'(ack_at_end), 0);
    chk(ack_at_rel == '0, "R4 ack at release", int'(ack_at_rel), 0);
    chk(n_ov == ISO_DLY, "R4 delay", n_ov, ISO_DLY);
    chk(clk_iso == 0 && iso_rel == 1, "R4 final iso", {clk_iso, iso_rel}, 1);
    @(negedge clk);
    chk(!done && !busy, "R10 done pulse", done, 0);
  endtask

  task automatic t_disable_iso();
    iso_cap = 1;
    do_op(0, 0);
    chk(got_done && !got_tmo, "R3 done", got_done, 1);
    chk(ack_at_end == '1, "R3 ack at done", int'(ack_at_end), int'({MASK_W{1'b1}}));
    chk(pdn == '1, "R3 pdn set", int'(pdn), int'({MASK_W{1'b1}}));
    chk(n_ov == ISO_DLY, "R5 clamp window", n_ov, ISO_DLY);
    chk(n_gap == 1, "R5 pdn after release drop", n_gap, 1);
    chk(clk_iso == 1 && iso_rel == 0, "R5 final iso", {clk_iso, iso_rel}, 2);
  endtask

  task automatic t_no_iso();
    @(negedge clk);
    iso_cap = 0;
    do_op(1, 0);
    chk(got_done && pdn == '0, "R2 no-cap up", got_done, 1);
    chk(iso_bad == 0, "R6 up const", iso_bad, 0);
    do_op(0, 0);
    chk(got_done && pdn == '1, "R3 no-cap down", got_done, 1);
    chk(iso_bad == 0, "R6 down const", iso_bad, 0);
    @(negedge clk);
    iso_cap = 1;
    @(negedge clk);
    chk(clk_iso == 1 && iso_rel == 0, "R6 held state", {clk_iso, iso_rel}, 2);
  endtask

  task automatic t_busy_ignore();
    iso_cap = 1;
    inj_at = 2; inj_both = 0;
    do_op(1, 0);
    chk(got_done && pdn == '0, "R8 ignore while busy", int'(pdn), 0);
    repeat (4) @(negedge clk);
    chk(!busy && pdn == '0 && iso_rel, "R8 no restart", busy, 0);
  endtask

  task automatic t_enable_timeout();
    iso_cap = 1;
    do_op(0, 0);
    stuck_mask = 4'b1000; stuck_val = 4'b1000;
    do_op(1, 0);
    chk(got_tmo && !got_done, "R7 up timeout", got_tmo, 1);
    chk(lat == TMO_CYC, "R7 up latency", lat, TMO_CYC);
    chk(!busy, "R7 idle at pulse", busy, 0);
    chk(pdn == '0 && iso_rel == 0 && clk_iso == 1, "R7 held", {iso_rel, clk_iso}, 1);
    @(negedge clk);
    chk(!tmo && !done, "R10 tmo pulse", tmo, 0);
    stuck_mask = '0;
  endtask

  task automatic t_both();
    iso_cap = 0;
    repeat (8) @(negedge clk);
    do_op(0, 1);
    chk(pdn_after_req == '0, "R9 up wins", int'(pdn_after_req), 0);
    chk(got_done && pdn == '0, "R9 final", int'(pdn), 0);
  endtask

  task automatic t_disable_timeout();
    iso_cap = 0;
    stuck_mask = 4'b0001; stuck_val = 4'b0000;
    do_op(0, 0);
    chk(got_tmo && !got_done, "R7 down timeout", got_tmo, 1);
    chk(lat == TMO_CYC, "R7 down latency", lat, TMO_CYC);
    chk(pdn == '1, "R7 down held", int'(pdn), int'({MASK_W{1'b1}}));
    stuck_mask = '0;
    repeat (8) @(negedge clk);
    do_op(1, 0);
    chk(got_done && pdn == '0, "R2 recovery", got_done, 1);
  endtask

  initial begin
    inj_at = -1; inj_both = 0;
    t_reset();
    t_enable_iso();
    t_disable_iso();
    t_no_iso();
    t_busy_ignore();
    t_enable_timeout();
    t_both();
    t_disable_timeout();
    repeat (4) @(negedge clk);
    finish_run();
  end
endmodule